// File: doc/BRIEF.md
# Output Load Diagnostic Sequencer

This block runs the load check that an amplifier performs on its bridge outputs when it leaves standby on its way to play. A single start request sends all output channels through four timed test phases together: short to ground, then short to supply, then open load, then shorted load. Each phase lasts a parameterised number of time-base ticks. The analog front end supplies one comparator bit per channel for each phase. The sequencer samples that bit on the final tick of the phase and records it in a per-channel status field.

When the shorted-load phase ends, the block produces a play-enable mask and a one-cycle done pulse. Any kind of short keeps a channel out of play. An open load is only reported and does not block play. Channels that are wired in parallel are tested in the same way as the others, because every channel runs the same phases at the same moment. The status and the mask stay valid until the next start.

Top module: `load_diag_seq`

## Requirements
- R1: After reset, phase_o is 0 (idle), status_o and play_en_o are all zero and done_o is low.
- R2: A start_i seen while the phase is idle clears status_o and play_en_o and sets phase_o to 1 in the following cycle. A start_i seen while a test is running has no effect.
- R3: The phase codes run 1 (short to ground), 2 (short to supply), 3 (open load), 4 (shorted load), then return to 0. No phase is skipped or repeated.
- R4: Each phase ends on exactly its parameterised number of ticks (LEN_GND, LEN_SUP, LEN_OPEN, LEN_SHORT). Cycles without tick_i do not advance the test, and ticks while idle are ignored.
- R5: The result for a phase is the value of that phase's comparator input on the phase's final tick. Its values on earlier ticks, and the comparator inputs of the other phases, are ignored. Channel c owns status_o[4c+3:4c], with bit 0 short to ground, bit 1 short to supply, bit 2 open load and bit 3 shorted load.
- R6: All channels are tested in the same phases at the same time, and each channel's result depends only on its own comparator bits.
- R7: Bit c of play_en_o is 1 exactly when channel c has none of the short-to-ground, short-to-supply or shorted-load bits set. An open-load bit alone does not clear it. The mask takes its new value in the same cycle that done_o is high.
- R8: done_o is high for exactly one cycle. That cycle follows the final tick of the shorted-load phase, and phase_o is 0 during it.
- R9: Once a test has finished, status_o and play_en_o hold their values until the next accepted start, whatever the comparator and tick inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to run the load check |
| tick_i | input | 1 | One-cycle time-base strobe that sets the phase durations |
| gnd_cmp_i | input | NUM_CH | Per-channel comparator result for the short-to-ground phase |
| sup_cmp_i | input | NUM_CH | Per-channel comparator result for the short-to-supply phase |
| open_cmp_i | input | NUM_CH | Per-channel comparator result for the open-load phase |
| short_cmp_i | input | NUM_CH | Per-channel comparator result for the shorted-load phase |
| phase_o | output | 3 | Current phase code (0 idle, 1 to 4 test phases) |
| status_o | output | 4*NUM_CH | Per-channel result flags, four per channel |
| play_en_o | output | NUM_CH | Channels allowed to enter play |
| done_o | output | 1 | One-cycle pulse at the end of the check |

## Verification
The assertions check several rules on every cycle. The phase may only step forward by one code. Each phase must close on exactly its tick count, which a counter in the checker measures. The status may change only on a final tick or an accepted start, and done must be a lone pulse that arrives with the phase back at idle. They also check that the mask agrees with the short flags whenever done is high. Some behaviour only the bench scenarios can show: that the flag landing in each field is the comparator value from the final tick and not from the noise driven on earlier ticks, that channels with mixed faults get the right independent verdicts, and that results survive idle-time ticks and comparator changes.

// File: rtl/load_diag_pkg.sv
package load_diag_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_GND   = 3'd1,
    PH_SUP   = 3'd2,
    PH_OPEN  = 3'd3,
    PH_SHORT = 3'd4
  } diag_phase_e;

  localparam int unsigned FLAGS_PER_CH = 4;
  localparam int unsigned SLOT_GND     = 0;
  localparam int unsigned SLOT_SUP     = 1;
  localparam int unsigned SLOT_OPEN    = 2;
  localparam int unsigned SLOT_SHORT   = 3;

  // Phase that follows p in the fixed test order.
  function automatic diag_phase_e next_phase(diag_phase_e p);
    case (p)
      PH_GND:   return PH_SUP;
      PH_SUP:   return PH_OPEN;
      PH_OPEN:  return PH_SHORT;
      default:  return PH_IDLE;
    endcase
  endfunction

  // Length in ticks of phase p; idle reports 1 so a limit of len-1 stays legal.
  function automatic int unsigned phase_len(diag_phase_e p, int unsigned l_gnd,
                                            int unsigned l_sup, int unsigned l_open,
                                            int unsigned l_short);
    case (p)
      PH_GND:   return l_gnd;
      PH_SUP:   return l_sup;
      PH_OPEN:  return l_open;
      PH_SHORT: return l_short;
      default:  return 1;
    endcase
  endfunction

  // Flag slot written by phase p.
  function automatic logic [1:0] phase_slot(diag_phase_e p);
    case (p)
      PH_SUP:   return 2'(SLOT_SUP);
      PH_OPEN:  return 2'(SLOT_OPEN);
      PH_SHORT: return 2'(SLOT_SHORT);
      default:  return 2'(SLOT_GND);
    endcase
  endfunction

  // A channel may play unless any short flag is set; open load alone is fine.
  function automatic logic may_play(logic [FLAGS_PER_CH-1:0] f);
    return !(f[SLOT_GND] || f[SLOT_SUP] || f[SLOT_SHORT]);
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/load_diag_phase.sv
module load_diag_phase
  import load_diag_pkg::*;
#(
  parameter int unsigned LEN_GND   = 20,
  parameter int unsigned LEN_SUP   = 20,
  parameter int unsigned LEN_OPEN  = 100,
  parameter int unsigned LEN_SHORT = 230,
  parameter int unsigned CNT_W     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        tick_i,
  output diag_phase_e phase_o,
  output logic        start_acc_o,
  output logic        last_tick_o,
  output logic        fin_o
);

  diag_phase_e      ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim = CNT_W'(phase_len(ph_q, LEN_GND, LEN_SUP, LEN_OPEN, LEN_SHORT) - 1);
  end

  assign start_acc_o = start_i && (ph_q == PH_IDLE);
  assign last_tick_o = tick_i && (ph_q != PH_IDLE) && (cnt_q == lim);
  assign fin_o       = last_tick_o && (ph_q == PH_SHORT);
  assign phase_o     = ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (start_acc_o) begin
      ph_q  <= PH_GND;
      cnt_q <= '0;
    end else if (last_tick_o) begin
      ph_q  <= next_phase(ph_q);
      cnt_q <= '0;
    end else if (tick_i && (ph_q != PH_IDLE)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/load_diag_chan.sv
module load_diag_chan
  import load_diag_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned ST_W  = NUM_CH * FLAGS_PER_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              last_tick_i,
  input  diag_phase_e       phase_i,
  input  logic [NUM_CH-1:0] gnd_cmp_i,
  input  logic [NUM_CH-1:0] sup_cmp_i,
  input  logic [NUM_CH-1:0] open_cmp_i,
  input  logic [NUM_CH-1:0] short_cmp_i,
  output logic [ST_W-1:0]   status_o,
  output logic [ST_W-1:0]   status_nxt_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [FLAGS_PER_CH-1:0] fl_q;
    logic [FLAGS_PER_CH-1:0] fl_d;
    logic                    hit;

    always_comb begin
      case (phase_i)
        PH_GND:   hit = gnd_cmp_i[c];
        PH_SUP:   hit = sup_cmp_i[c];
        PH_OPEN:  hit = open_cmp_i[c];
        PH_SHORT: hit = short_cmp_i[c];
        default:  hit = 1'b0;
      endcase
      fl_d = fl_q;
      if (clr_i) begin
        fl_d = '0;
      end else if (last_tick_i) begin
        fl_d[phase_slot(phase_i)] = hit;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) fl_q <= '0;
      else        fl_q <= fl_d;
    end

    assign status_o[c*FLAGS_PER_CH +: FLAGS_PER_CH]     = fl_q;
    assign status_nxt_o[c*FLAGS_PER_CH +: FLAGS_PER_CH] = fl_d;
  end

endmodule

// File: rtl/load_diag_verdict.sv
module load_diag_verdict
  import load_diag_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned ST_W  = NUM_CH * FLAGS_PER_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              fin_i,
  input  logic [ST_W-1:0]   status_nxt_i,
  output logic [NUM_CH-1:0] play_en_o,
  output logic              done_o
);

  logic [NUM_CH-1:0] play_d;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ok
    assign play_d[c] = may_play(status_nxt_i[c*FLAGS_PER_CH +: FLAGS_PER_CH]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      play_en_o <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= fin_i;
      if (clr_i)      play_en_o <= '0;
      else if (fin_i) play_en_o <= play_d;
    end
  end

endmodule

// File: rtl/load_diag_seq.sv
module load_diag_seq
  import load_diag_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned LEN_GND   = 20,
  parameter int unsigned LEN_SUP   = 20,
  parameter int unsigned LEN_OPEN  = 100,
  parameter int unsigned LEN_SHORT = 230,
  localparam int unsigned ST_W     = NUM_CH * FLAGS_PER_CH,
  localparam int unsigned MAX_LEN  = max4(LEN_GND, LEN_SUP, LEN_OPEN, LEN_SHORT),
  localparam int unsigned CNT_W    = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic [NUM_CH-1:0] gnd_cmp_i,
  input  logic [NUM_CH-1:0] sup_cmp_i,
  input  logic [NUM_CH-1:0] open_cmp_i,
  input  logic [NUM_CH-1:0] short_cmp_i,
  output logic [2:0]        phase_o,
  output logic [ST_W-1:0]   status_o,
  output logic [NUM_CH-1:0] play_en_o,
  output logic              done_o
);

  // Internal events, named for the checker.
  diag_phase_e     phase_w;
  logic            start_acc_w;
  logic            last_tick_w;
  logic            fin_w;
  logic [ST_W-1:0] status_nxt_w;

  load_diag_phase #(
    .LEN_GND  (LEN_GND),
    .LEN_SUP  (LEN_SUP),
    .LEN_OPEN (LEN_OPEN),
    .LEN_SHORT(LEN_SHORT),
    .CNT_W    (CNT_W)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .tick_i     (tick_i),
    .phase_o    (phase_w),
    .start_acc_o(start_acc_w),
    .last_tick_o(last_tick_w),
    .fin_o      (fin_w)
  );

  load_diag_chan #(.NUM_CH(NUM_CH)) u_chan (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (start_acc_w),
    .last_tick_i (last_tick_w),
    .phase_i     (phase_w),
    .gnd_cmp_i   (gnd_cmp_i),
    .sup_cmp_i   (sup_cmp_i),
    .open_cmp_i  (open_cmp_i),
    .short_cmp_i (short_cmp_i),
    .status_o    (status_o),
    .status_nxt_o(status_nxt_w)
  );

  load_diag_verdict #(.NUM_CH(NUM_CH)) u_verdict (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (start_acc_w),
    .fin_i       (fin_w),
    .status_nxt_i(status_nxt_w),
    .play_en_o   (play_en_o),
    .done_o      (done_o)
  );

  assign phase_o = phase_w;

endmodule

// File: rtl/load_diag_seq_chk.sv
module load_diag_seq_chk
  import load_diag_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned LEN_GND   = 20,
  parameter int unsigned LEN_SUP   = 20,
  parameter int unsigned LEN_OPEN  = 100,
  parameter int unsigned LEN_SHORT = 230,
  localparam int unsigned ST_W     = NUM_CH * FLAGS_PER_CH
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              tick_i,
  input logic [2:0]        phase_o,
  input logic [ST_W-1:0]   status_o,
  input logic [NUM_CH-1:0] play_en_o,
  input logic              done_o,
  input logic              last_tick
);

  logic [2:0]        ph_q;
  int unsigned       ck_cnt;
  logic [NUM_CH-1:0] exp_play;
  logic              go;
  int unsigned       prev_len;
  int unsigned       cur_len;
  logic [2:0]        step_code;

  assign go        = start_i && (phase_o == 3'd0);
  assign prev_len  = phase_len(diag_phase_e'(ph_q), LEN_GND, LEN_SUP, LEN_OPEN, LEN_SHORT);
  assign cur_len   = phase_len(diag_phase_e'(phase_o), LEN_GND, LEN_SUP, LEN_OPEN, LEN_SHORT);
  assign step_code = (ph_q == 3'd4) ? 3'd0 : ph_q + 3'd1;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_exp
    assign exp_play[c] = ~(status_o[4*c] | status_o[4*c+1] | status_o[4*c+3]);
  end

  // Ticks observed in the current phase, restarted whenever the phase code moves.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= 3'd0;
      ck_cnt <= 0;
    end else begin
      ph_q <= phase_o;
      if (phase_o != ph_q)
        ck_cnt <= (tick_i && phase_o != 3'd0) ? 1 : 0;
      else if (tick_i && phase_o != 3'd0)
        ck_cnt <= ck_cnt + 1;
    end
  end

  AST_START_ENTERS_GND: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (phase_o == 3'd1 && status_o == '0 && play_en_o == '0)); // R2

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && phase_o != 3'd0 && !last_tick) |=> (phase_o == $past(phase_o))); // R2

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != ph_q) |-> ((phase_o == step_code) || (ph_q == 3'd0 && phase_o == 3'd1))); // R3

  AST_LAST_TICK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |=> (phase_o != $past(phase_o))); // R3

  AST_PHASE_LEN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != ph_q && ph_q != 3'd0) |-> (ck_cnt == prev_len)); // R4

  AST_PHASE_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != 3'd0 && phase_o == ph_q) |-> (ck_cnt < cur_len)); // R4

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd0 && !start_i) |=> (phase_o == 3'd0)); // R4

  AST_STATUS_ONLY_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!last_tick && !go) |=> $stable(status_o)); // R5

  AST_PLAY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (play_en_o == exp_play)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (phase_o == 3'd0 && ph_q == 3'd4)); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd0 && !start_i) |=> ($stable(status_o) && $stable(play_en_o))); // R9

endmodule

bind load_diag_seq load_diag_seq_chk #(
  .NUM_CH   (NUM_CH),
  .LEN_GND  (LEN_GND),
  .LEN_SUP  (LEN_SUP),
  .LEN_OPEN (LEN_OPEN),
  .LEN_SHORT(LEN_SHORT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .tick_i   (tick_i),
  .phase_o  (phase_o),
  .status_o (status_o),
  .play_en_o(play_en_o),
  .done_o   (done_o),
  .last_tick(last_tick_w)
);

// File: tb/load_diag_seq_tb.sv
module load_diag_seq_tb;

  localparam int NCH = 4;
  localparam int LG  = 3;
  localparam int LS  = 2;
  localparam int LO  = 4;
  localparam int LSH = 5;
  localparam int SW  = NCH * 4;

  typedef struct packed {
    logic [SW-1:0]  st;
    logic [NCH-1:0] pl;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start_i = 1'b0;
  logic           tick_i = 1'b0;
  logic [NCH-1:0] gnd_cmp_i = '0;
  logic [NCH-1:0] sup_cmp_i = '0;
  logic [NCH-1:0] open_cmp_i = '0;
  logic [NCH-1:0] short_cmp_i = '0;
  logic [2:0]     phase_o;
  logic [SW-1:0]  status_o;
  logic [NCH-1:0] play_en_o;
  logic           done_o;

  int   checks = 0;
  int   errors = 0;
  int   dones  = 0;
  logic prev_done = 1'b0;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  load_diag_seq #(
    .NUM_CH(NCH), .LEN_GND(LG), .LEN_SUP(LS), .LEN_OPEN(LO), .LEN_SHORT(LSH)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
    .gnd_cmp_i(gnd_cmp_i), .sup_cmp_i(sup_cmp_i), .open_cmp_i(open_cmp_i),
    .short_cmp_i(short_cmp_i), .phase_o(phase_o), .status_o(status_o),
    .play_en_o(play_en_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: every done pulse pops one expected result from the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o && prev_done)
        check(1'b0, "R8", "done longer than one cycle", 32'd1, 32'd0);
      if (done_o) begin
        dones++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(status_o == e.st, "R5", "status at done", 32'(status_o), 32'(e.st));
          check(play_en_o == e.pl, "R7", "play mask at done", 32'(play_en_o), 32'(e.pl));
          check(phase_o == 3'd0, "R8", "phase at done", 32'(phase_o), 32'd0);
        end
      end
    end
    prev_done = done_o;
  end

  function automatic exp_t predict(input logic [NCH-1:0] g, s, o, sh);
    exp_t e;
    for (int c = 0; c < NCH; c++) begin
      e.st[4*c+0] = g[c];
      e.st[4*c+1] = s[c];
      e.st[4*c+2] = o[c];
      e.st[4*c+3] = sh[c];
      e.pl[c]     = !(g[c] || s[c] || sh[c]);
    end
    return e;
  endfunction

  // Driver: one full diagnostic run. Non-final ticks and the other phases'
  // comparators carry the inverted pattern, so only the final tick may count (R5).
  task automatic run_diag(input logic [NCH-1:0] g, s, o, sh,
                          input int gap, input bit busy_start);
    logic [NCH-1:0] fin [4];
    int lens [4];
    fin[0] = g; fin[1] = s; fin[2] = o; fin[3] = sh;
    lens[0] = LG; lens[1] = LS; lens[2] = LO; lens[3] = LSH;
    exp_q.push_back(predict(g, s, o, sh));
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(phase_o == 3'd1, "R2", "phase after start", 32'(phase_o), 32'd1);
    check(status_o == '0, "R2", "status cleared on start", 32'(status_o), 32'd0);
    check(play_en_o == '0, "R2", "mask cleared on start", 32'(play_en_o), 32'd0);
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < lens[p]; k++) begin
        bit last;
        last = (k == lens[p] - 1);
        gnd_cmp_i   = (last && p == 0) ? fin[0] : ~fin[0];
        sup_cmp_i   = (last && p == 1) ? fin[1] : ~fin[1];
        open_cmp_i  = (last && p == 2) ? fin[2] : ~fin[2];
        short_cmp_i = (last && p == 3) ? fin[3] : ~fin[3];
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        if (!last) begin
          check(phase_o == 3'(p + 1), "R4", "phase held before final tick",
                32'(phase_o), 32'(p + 1));
          for (int w = 0; w < gap; w++) @(negedge clk);
          if (gap > 0)
            check(phase_o == 3'(p + 1), "R4", "no advance without tick",
                  32'(phase_o), 32'(p + 1));
          if (busy_start && p == 2 && k == 0) begin
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check(phase_o == 3'd3, "R2", "start while busy ignored", 32'(phase_o), 32'd3);
          end
        end else begin
          check(phase_o == ((p == 3) ? 3'd0 : 3'(p + 2)), "R3", "phase after final tick",
                32'(phase_o), (p == 3) ? 32'd0 : 32'(p + 2));
        end
      end
    end
    @(negedge clk);
  endtask

  initial begin
    exp_t e;
    logic [SW-1:0]  st_hold;
    logic [NCH-1:0] pl_hold;
    repeat (3) @(negedge clk);
    check(phase_o == 3'd0, "R1", "reset phase", 32'(phase_o), 32'd0);
    check(status_o == '0, "R1", "reset status", 32'(status_o), 32'd0);
    check(play_en_o == '0, "R1", "reset mask", 32'(play_en_o), 32'd0);
    check(done_o == 1'b0, "R1", "reset done", 32'(done_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: ticks while idle do nothing.
    tick_i = 1'b1;
    repeat (3) @(negedge clk);
    tick_i = 1'b0;
    check(phase_o == 3'd0, "R4", "idle ticks ignored", 32'(phase_o), 32'd0);

    // Clean loads: all channels may play.
    run_diag(4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 1'b0);
    // R6/R7: one fault type per channel, open only on ch2 must still play.
    run_diag(4'b0001, 4'b0010, 4'b0100, 4'b1000, 1, 1'b0);
    // R7: channel 0 open plus shorted, ch3 open only, with busy start (R2).
    run_diag(4'b0000, 4'b0000, 4'b1001, 4'b0001, 2, 1'b1);
    // R6: paralleled pair ch1/ch0 show identical shorts to supply.
    run_diag(4'b0000, 4'b0011, 4'b0000, 4'b0000, 0, 1'b0);
    // All faults everywhere.
    run_diag(4'b1111, 4'b1111, 4'b1111, 4'b1111, 0, 1'b0);

    // R9: results hold through idle ticks and comparator changes.
    e = predict(4'b1111, 4'b1111, 4'b1111, 4'b1111);
    st_hold = status_o;
    pl_hold = play_en_o;
    gnd_cmp_i = 4'b0000; sup_cmp_i = 4'b0000; open_cmp_i = 4'b0000; short_cmp_i = 4'b0000;
    tick_i = 1'b1;
    repeat (4) @(negedge clk);
    tick_i = 1'b0;
    @(negedge clk);
    check(status_o == e.st && status_o == st_hold, "R9", "status held",
          32'(status_o), 32'(e.st));
    check(play_en_o == e.pl && play_en_o == pl_hold, "R9", "mask held",
          32'(play_en_o), 32'(e.pl));

    // Final run restores a mixed verdict.
    run_diag(4'b0100, 4'b0000, 4'b0010, 4'b0000, 0, 1'b0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8", "all runs produced done", 32'(exp_q.size()), 32'd0);
    check(dones == 6, "R8", "done pulse count", 32'(dones), 32'd6);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule